// File: doc/BRIEF.md
# Virtualized Counter Offset Unit

The unit holds a virtual offset register and turns a free-running physical count into a virtual count: the virtual count is the physical count minus the stored offset. Software reads and writes the offset through a system-register request port. Each request carries its five-field access encoding and the privilege level (0 to 3) of the requester. The unit answers each claimed request in the same cycle with a 2-bit status.

A request can be serviced against the register itself, forwarded to a memory slot for nested virtualization, trapped to the hypervisor level, or reported as undefined. The virtual count falls back to a zero offset in the host-mode cases selected by the E2H and TGE control bits and by the level that is reading the count. Two parameters set the build: the counter width, and whether a hypervisor level exists. The unit does not contain the memory behind the redirect, and it does not handle exceptions.

Top module: `vcnt_offset_unit`

## Requirements
- R1: With no zero-offset case active, `vcnt_o` equals the zero-extended physical count minus the zero-extended offset, modulo 2^64. The subtraction wraps when the offset is larger than the count.
- R2: When `ctl_e2h_i`=1 and `vcnt_lvl_i`=2, `vcnt_o` equals the physical count. When `ctl_e2h_i`=0 and the reader is at level 2, the offset is applied.
- R3: When `ctl_e2h_i`=1, `ctl_tge_i`=1 and `vcnt_lvl_i`=0, `vcnt_o` equals the physical count. With `ctl_tge_i`=0 at level 0, the offset is applied.
- R4: The unit claims only the access encoding op0=2'b11, op1=3'b100, CRn=4'b1110, CRm=4'b0000, op2=3'b011. For any other encoding `rsp_valid_o` and `mem_valid_o` stay 0, and the offset is unchanged.
- R5: A claimed access from level 0 responds with status 3 (undefined) and leaves the offset unchanged.
- R6: A claimed access from level 1 with NV2=1 and NV=1 responds with status 1 (redirect). It raises `mem_valid_o` with `mem_addr_o`=0x060, sets `mem_write_o` to the request direction and sets `mem_wdata_o` to the write data. A read returns `mem_rdata_i` on `rsp_rdata_o`. The offset is unchanged.
- R7: A claimed access from level 1 with NV=1 and NV2=0 responds with status 2 (trap) and `rsp_trap_ec_o`=0x18. With NV=0 it responds with status 3. Neither changes the offset.
- R8: A claimed access from level 2 or 3 responds with status 0. A read returns the offset. A write stores the data at the next clock edge: `vcnt_o` still shows the old offset during the write cycle and shows the new one from the following cycle.
- R9: After reset the offset is zero.
- R10: With `HYP_IMPL`=0 the offset reads as zero, writes are ignored, `vcnt_o` equals the physical count, and level-1 accesses respond with status 3.
- R11: With `CNT_W`<64 only the low `CNT_W` bits of the offset are stored. The upper bits read as zero, and the offset is zero-extended in the virtual count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phys_cnt_i | input | CNT_W | Physical count |
| vcnt_lvl_i | input | 2 | Privilege level reading the virtual count |
| ctl_e2h_i | input | 1 | Host-extension flag |
| ctl_tge_i | input | 1 | Trap-general flag |
| ctl_nv_i | input | 1 | Nested-virtualization enable |
| ctl_nv2_i | input | 1 | Nested-virtualization redirect enable |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_lvl_i | input | 2 | Requester privilege level |
| req_op0_i | input | 2 | Encoding field op0 |
| req_op1_i | input | 3 | Encoding field op1 |
| req_crn_i | input | 4 | Encoding field CRn |
| req_crm_i | input | 4 | Encoding field CRm |
| req_op2_i | input | 3 | Encoding field op2 |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Request claimed; status valid |
| rsp_status_o | output | 2 | 0 ok, 1 redirect, 2 trap, 3 undefined |
| rsp_rdata_o | output | 64 | Read data |
| rsp_trap_ec_o | output | 6 | Trap syndrome class |
| mem_valid_o | output | 1 | Redirected slot access |
| mem_write_o | output | 1 | Slot access direction |
| mem_addr_o | output | 12 | Slot address |
| mem_wdata_o | output | 64 | Slot write data |
| mem_rdata_i | input | 64 | Slot read data |
| vcnt_o | output | 64 | Virtual count |

## Verification
The assertions check the following on every cycle:
- level-0 accesses are undefined;
- a redirect status always comes with a slot access at 0x060;
- a trap always carries class 0x18;
- the offset holds across any cycle without an accepted write;
- a forced-zero case makes the virtual count equal the physical count;
- an accepted write shows up in the virtual count one cycle later.

Only the bench scenarios show the full picture. These cover the read-back values through the request port, the wrap of the subtraction, the complete list of override cases at each level, the rejection of foreign encodings, and the builds without a hypervisor level or with a 32-bit counter.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_REDIR = 2'd1,
    ST_TRAP  = 2'd2,
    ST_UNDEF = 2'd3
  } vcnt_status_e;

  localparam logic [1:0]  ENC_OP0 = 2'b11;
  localparam logic [2:0]  ENC_OP1 = 3'b100;
  localparam logic [3:0]  ENC_CRN = 4'b1110;
  localparam logic [3:0]  ENC_CRM = 4'b0000;
  localparam logic [2:0]  ENC_OP2 = 3'b011;
  localparam logic [11:0] SLOT_ADDR = 12'h060;
  localparam logic [5:0]  TRAP_EC = 6'h18;
endpackage

// File: rtl/vcnt_access_dec.sv
module vcnt_access_dec
  import vcnt_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic [1:0] lvl_i,
  input  logic       nv_i,
  input  logic       nv2_i,
  output logic       claim_o,
  output vcnt_status_e status_o
);
  assign claim_o = valid_i && op0_i == ENC_OP0 && op1_i == ENC_OP1 &&
                   crn_i == ENC_CRN && crm_i == ENC_CRM && op2_i == ENC_OP2;

  always_comb begin
    unique case (lvl_i)
      2'd0: status_o = ST_UNDEF;
      2'd1: begin
        if (nv_i && nv2_i) status_o = ST_REDIR;
        else if (nv_i)     status_o = ST_TRAP;
        else               status_o = ST_UNDEF;
      end
      default: status_o = ST_OK;
    endcase
  end
endmodule

// File: rtl/vcnt_off_reg.sv
module vcnt_off_reg #(
  parameter int unsigned CNT_W    = 64,
  parameter bit          HYP_IMPL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [63:0]      off_o
);
  logic [CNT_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                off_q <= '0;
    else if (we_i && HYP_IMPL)  off_q <= wdata_i;
  end

  // zero-extend; without a hypervisor level the value is fixed at zero
  always_comb begin
    off_o = '0;
    if (HYP_IMPL) off_o[CNT_W-1:0] = off_q;
  end
endmodule

// File: rtl/vcnt_calc.sv
module vcnt_calc #(
  parameter int unsigned CNT_W    = 64,
  parameter bit          HYP_IMPL = 1'b1
) (
  input  logic [CNT_W-1:0] phys_i,
  input  logic [63:0]      off_i,
  input  logic             e2h_i,
  input  logic             tge_i,
  input  logic [1:0]       lvl_i,
  output logic [63:0]      vcnt_o
);
  logic        zero_off;
  logic [63:0] phys_ext;

  assign zero_off = !HYP_IMPL || (e2h_i && lvl_i == 2'd2) ||
                    (e2h_i && tge_i && lvl_i == 2'd0);

  always_comb begin
    phys_ext = '0;
    phys_ext[CNT_W-1:0] = phys_i;
  end

  assign vcnt_o = zero_off ? phys_ext : phys_ext - off_i;
endmodule

// File: rtl/vcnt_offset_unit.sv
module vcnt_offset_unit
  import vcnt_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter bit          HYP_IMPL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] phys_cnt_i,
  input  logic [1:0]       vcnt_lvl_i,
  input  logic             ctl_e2h_i,
  input  logic             ctl_tge_i,
  input  logic             ctl_nv_i,
  input  logic             ctl_nv2_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [1:0]       req_lvl_i,
  input  logic [1:0]       req_op0_i,
  input  logic [2:0]       req_op1_i,
  input  logic [3:0]       req_crn_i,
  input  logic [3:0]       req_crm_i,
  input  logic [2:0]       req_op2_i,
  input  logic [63:0]      req_wdata_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_status_o,
  output logic [63:0]      rsp_rdata_o,
  output logic [5:0]       rsp_trap_ec_o,
  output logic             mem_valid_o,
  output logic             mem_write_o,
  output logic [11:0]      mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic [63:0]      mem_rdata_i,
  output logic [63:0]      vcnt_o
);
  logic         claim;
  vcnt_status_e status;
  logic [63:0]  off_val;
  logic         reg_we;

  vcnt_access_dec u_dec (
    .valid_i (req_valid_i),
    .op0_i   (req_op0_i),
    .op1_i   (req_op1_i),
    .crn_i   (req_crn_i),
    .crm_i   (req_crm_i),
    .op2_i   (req_op2_i),
    .lvl_i   (req_lvl_i),
    .nv_i    (ctl_nv_i && HYP_IMPL),
    .nv2_i   (ctl_nv2_i && HYP_IMPL),
    .claim_o (claim),
    .status_o(status)
  );

  assign reg_we = claim && status == ST_OK && req_write_i;

  vcnt_off_reg #(.CNT_W(CNT_W), .HYP_IMPL(HYP_IMPL)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .wdata_i(req_wdata_i[CNT_W-1:0]),
    .off_o  (off_val)
  );

  vcnt_calc #(.CNT_W(CNT_W), .HYP_IMPL(HYP_IMPL)) u_calc (
    .phys_i(phys_cnt_i),
    .off_i (off_val),
    .e2h_i (ctl_e2h_i),
    .tge_i (ctl_tge_i),
    .lvl_i (vcnt_lvl_i),
    .vcnt_o(vcnt_o)
  );

  assign rsp_valid_o   = claim;
  assign rsp_status_o  = claim ? status : 2'd0;
  assign rsp_trap_ec_o = (claim && status == ST_TRAP) ? TRAP_EC : 6'd0;
  assign mem_valid_o   = claim && status == ST_REDIR;
  assign mem_write_o   = mem_valid_o && req_write_i;
  assign mem_addr_o    = mem_valid_o ? SLOT_ADDR : 12'd0;
  assign mem_wdata_o   = mem_write_o ? req_wdata_i : 64'd0;

  always_comb begin
    rsp_rdata_o = '0;
    if (claim && !req_write_i) begin
      if (status == ST_OK)         rsp_rdata_o = off_val;
      else if (status == ST_REDIR) rsp_rdata_o = mem_rdata_i;
    end
  end
endmodule

// File: rtl/vcnt_offset_unit_chk.sv
module vcnt_offset_unit_chk #(
  parameter int unsigned CNT_W    = 64,
  parameter bit          HYP_IMPL = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] phys_cnt_i,
  input logic [1:0]       vcnt_lvl_i,
  input logic             ctl_e2h_i,
  input logic             ctl_tge_i,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [1:0]       req_lvl_i,
  input logic [63:0]      req_wdata_i,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_status_o,
  input logic [5:0]       rsp_trap_ec_o,
  input logic             mem_valid_o,
  input logic [11:0]      mem_addr_o,
  input logic [63:0]      off_val,
  input logic [63:0]      vcnt_o
);
  localparam logic [63:0] W_MASK = (CNT_W >= 64) ? {64{1'b1}} : ((64'd1 << CNT_W) - 64'd1);

  logic [63:0] phys_ext;
  logic        zf;
  logic        acc_wr;
  always_comb begin
    phys_ext = '0;
    phys_ext[CNT_W-1:0] = phys_cnt_i;
  end
  assign zf = !HYP_IMPL || (ctl_e2h_i && vcnt_lvl_i == 2'd2) ||
              (ctl_e2h_i && ctl_tge_i && vcnt_lvl_i == 2'd0);
  assign acc_wr = rsp_valid_o && rsp_status_o == 2'd0 && req_write_i && req_lvl_i[1];

  a_r5_el0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && req_lvl_i == 2'd0) |-> rsp_status_o == 2'd3);

  a_r6_redirect_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd1) |-> (mem_valid_o && mem_addr_o == 12'h060 && req_lvl_i == 2'd1));

  a_r7_trap_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd2) |-> (rsp_trap_ec_o == 6'h18 && req_lvl_i == 2'd1));

  a_r4_no_claim_no_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !mem_valid_o);

  a_r8_hold_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_wr |=> $stable(off_val));

  a_r8_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HYP_IMPL && acc_wr) |=> (zf || vcnt_o == phys_ext - ($past(req_wdata_i) & W_MASK)));

  a_r2_r3_zero_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zf |-> vcnt_o == phys_ext);

  logic unused_ok;
  assign unused_ok = req_valid_i;
endmodule

bind vcnt_offset_unit vcnt_offset_unit_chk #(.CNT_W(CNT_W), .HYP_IMPL(HYP_IMPL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phys_cnt_i(phys_cnt_i), .vcnt_lvl_i(vcnt_lvl_i),
  .ctl_e2h_i(ctl_e2h_i), .ctl_tge_i(ctl_tge_i), .req_valid_i(req_valid_i),
  .req_write_i(req_write_i), .req_lvl_i(req_lvl_i), .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o), .rsp_trap_ec_o(rsp_trap_ec_o),
  .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o), .off_val(off_val), .vcnt_o(vcnt_o)
);

// File: tb/vcnt_offset_unit_tb_top.sv
module vcnt_offset_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] phys = '0;
  logic [1:0]  vlvl = 2'd1;
  logic e2h = 0, tge = 0, nv = 0, nv2 = 0;
  logic valid = 0, wr = 0;
  logic [1:0] lvl = 0;
  logic [1:0] op0 = 2'b11; logic [2:0] op1 = 3'b100;
  logic [3:0] crn = 4'b1110, crm = 4'b0000; logic [2:0] op2 = 3'b011;
  logic [63:0] wdata = '0, mrdata = '0;

  logic a_rv, b_rv, n_rv;
  logic [1:0] a_st, b_st, n_st;
  logic [63:0] a_rd, b_rd, n_rd, a_v, b_v, n_v, a_mwd;
  logic [5:0] a_ec, b_ec, n_ec;
  logic a_mv, b_mv, n_mv, a_mw, b_mw, n_mw;
  logic [11:0] a_ma, b_ma, n_ma;
  logic [63:0] b_mwd, n_mwd;

  vcnt_offset_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phys_cnt_i(phys), .vcnt_lvl_i(vlvl),
    .ctl_e2h_i(e2h), .ctl_tge_i(tge), .ctl_nv_i(nv), .ctl_nv2_i(nv2),
    .req_valid_i(valid), .req_write_i(wr), .req_lvl_i(lvl), .req_op0_i(op0),
    .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
    .req_wdata_i(wdata), .rsp_valid_o(a_rv), .rsp_status_o(a_st), .rsp_rdata_o(a_rd),
    .rsp_trap_ec_o(a_ec), .mem_valid_o(a_mv), .mem_write_o(a_mw), .mem_addr_o(a_ma),
    .mem_wdata_o(a_mwd), .mem_rdata_i(mrdata), .vcnt_o(a_v));

  vcnt_offset_unit #(.HYP_IMPL(1'b0)) dut_nohyp_i (
    .clk_i(clk), .rst_ni(rst_n), .phys_cnt_i(phys), .vcnt_lvl_i(vlvl),
    .ctl_e2h_i(e2h), .ctl_tge_i(tge), .ctl_nv_i(nv), .ctl_nv2_i(nv2),
    .req_valid_i(valid), .req_write_i(wr), .req_lvl_i(lvl), .req_op0_i(op0),
    .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
    .req_wdata_i(wdata), .rsp_valid_o(b_rv), .rsp_status_o(b_st), .rsp_rdata_o(b_rd),
    .rsp_trap_ec_o(b_ec), .mem_valid_o(b_mv), .mem_write_o(b_mw), .mem_addr_o(b_ma),
    .mem_wdata_o(b_mwd), .mem_rdata_i(mrdata), .vcnt_o(b_v));

  vcnt_offset_unit #(.CNT_W(32)) dut_narrow_i (
    .clk_i(clk), .rst_ni(rst_n), .phys_cnt_i(phys[31:0]), .vcnt_lvl_i(vlvl),
    .ctl_e2h_i(e2h), .ctl_tge_i(tge), .ctl_nv_i(nv), .ctl_nv2_i(nv2),
    .req_valid_i(valid), .req_write_i(wr), .req_lvl_i(lvl), .req_op0_i(op0),
    .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
    .req_wdata_i(wdata), .rsp_valid_o(n_rv), .rsp_status_o(n_st), .rsp_rdata_o(n_rd),
    .rsp_trap_ec_o(n_ec), .mem_valid_o(n_mv), .mem_write_o(n_mw), .mem_addr_o(n_ma),
    .mem_wdata_o(n_mwd), .mem_rdata_i(mrdata), .vcnt_o(n_v));

  int n_tests = 0, n_fail = 0;
  // sampled response of the main instance
  logic s_rv, s_mv, s_mw; logic [1:0] s_st; logic [63:0] s_rd, s_v, s_mwd; logic [5:0] s_ec; logic [11:0] s_ma;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic req(input bit w, input logic [1:0] l, input logic [63:0] d);
    @(negedge clk);
    valid = 1; wr = w; lvl = l; wdata = d;
    #5;
    s_rv = a_rv; s_st = a_st; s_rd = a_rd; s_ec = a_ec; s_v = a_v;
    s_mv = a_mv; s_mw = a_mw; s_ma = a_ma; s_mwd = a_mwd;
    @(posedge clk); #1;
    valid = 0; wr = 0;
  endtask

  task automatic rd_off(output logic [63:0] v);
    req(0, 2'd2, 64'd0);
    v = s_rd;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    phys = 64'h1234; vlvl = 2'd1; #1;
    chk(a_v == 64'h1234, "R9 vcnt after reset", a_v, 64'h1234);
    rd_off(v);
    chk(v == 0 && s_rv && s_st == 0, "R9 offset after reset", v, 0);
  endtask

  task automatic t_direct();
    logic [63:0] v;
    phys = 64'h1000;
    req(1, 2'd2, 64'h100);
    chk(s_st == 0 && s_rv, "R8 write status", {62'd0, s_st}, 0);
    chk(s_v == 64'h1000, "R8 old offset in write cycle", s_v, 64'h1000);
    #2;
    chk(a_v == 64'hF00, "R8 new offset next cycle", a_v, 64'hF00);
    rd_off(v);
    chk(v == 64'h100, "R8 readback", v, 64'h100);
    req(1, 2'd3, 64'h0000_0001_0000_0050);
    req(0, 2'd3, 64'd0);
    chk(s_rd == 64'h0000_0001_0000_0050 && s_st == 0, "R8 level3 readback", s_rd, 64'h0000_0001_0000_0050);
    phys = 64'h0000_0002_0000_0060; #1;
    chk(a_v == 64'h0000_0001_0000_0010, "R1 subtraction", a_v, 64'h0000_0001_0000_0010);
    phys = 64'h10; #1;
    chk(a_v == 64'hFFFF_FFFE_FFFF_FFC0, "R1 wrap", a_v, 64'hFFFF_FFFE_FFFF_FFC0);
  endtask

  task automatic t_override();
    // offset is 0x1_0000_0050 here
    phys = 64'h0000_0005_0000_0050;
    e2h = 1; tge = 0; vlvl = 2'd2; #1;
    chk(a_v == phys, "R2 e2h level2 zero offset", a_v, phys);
    e2h = 0; #1;
    chk(a_v == 64'h0000_0004_0000_0000, "R2 e2h=0 level2 offset used", a_v, 64'h0000_0004_0000_0000);
    e2h = 1; tge = 1; vlvl = 2'd0; #1;
    chk(a_v == phys, "R3 e2h tge level0 zero offset", a_v, phys);
    tge = 0; #1;
    chk(a_v == 64'h0000_0004_0000_0000, "R3 tge=0 level0 offset used", a_v, 64'h0000_0004_0000_0000);
    e2h = 1; tge = 1; vlvl = 2'd1; #1;
    chk(a_v == 64'h0000_0004_0000_0000, "R3 level1 offset used", a_v, 64'h0000_0004_0000_0000);
    e2h = 0; tge = 0; vlvl = 2'd1;
  endtask

  task automatic t_el0_el1();
    logic [63:0] v;
    req(1, 2'd0, 64'hDEAD);
    chk(s_st == 3 && s_rv, "R5 level0 undefined", {62'd0, s_st}, 3);
    nv = 1; nv2 = 1; mrdata = 64'hCAFE_F00D_1234_5678;
    req(1, 2'd1, 64'hBEEF);
    chk(s_st == 1 && s_mv && s_mw && s_ma == 12'h060 && s_mwd == 64'hBEEF, "R6 redirect write", {52'd0, s_ma}, 64'h060);
    req(0, 2'd1, 64'd0);
    chk(s_st == 1 && s_mv && !s_mw && s_rd == mrdata, "R6 redirect read", s_rd, mrdata);
    nv2 = 0;
    req(1, 2'd1, 64'hBEEF);
    chk(s_st == 2 && s_ec == 6'h18 && !s_mv, "R7 trap", {58'd0, s_ec}, 64'h18);
    nv = 0; nv2 = 1;
    req(1, 2'd1, 64'hBEEF);
    chk(s_st == 3 && !s_mv, "R7 nv=0 undefined", {62'd0, s_st}, 3);
    nv2 = 0;
    rd_off(v);
    chk(v == 64'h0000_0001_0000_0050, "R5 R6 R7 offset unchanged", v, 64'h0000_0001_0000_0050);
  endtask

  task automatic t_encoding();
    logic [63:0] v;
    nv = 1; nv2 = 1; crm = 4'b0001;
    req(1, 2'd1, 64'h77);
    chk(!s_rv && !s_mv, "R4 foreign encoding unclaimed", {63'd0, s_rv}, 0);
    nv = 0; nv2 = 0; crm = 4'b0000; op2 = 3'b010;
    req(1, 2'd2, 64'h77);
    chk(!s_rv, "R4 foreign op2 unclaimed", {63'd0, s_rv}, 0);
    op2 = 3'b011; op1 = 3'b000;
    req(1, 2'd3, 64'h77);
    op1 = 3'b100;
    rd_off(v);
    chk(v == 64'h0000_0001_0000_0050, "R4 offset unchanged", v, 64'h0000_0001_0000_0050);
  endtask

  task automatic t_nohyp_narrow();
    req(1, 2'd2, 64'hFFFF_FFFF_1234_5678);
    req(0, 2'd2, 64'd0);
    chk(b_rd == 0 && b_st == 0, "R10 reads zero after write", b_rd, 0);
    chk(n_rd == 64'h1234_5678, "R11 upper bits zero", n_rd, 64'h1234_5678);
    phys = 64'h0000_0000_2000_0000; vlvl = 2'd1; #1;
    chk(b_v == phys, "R10 vcnt equals phys", b_v, phys);
    chk(n_v == 64'h0000_0000_0DCB_A988, "R11 zero-extended subtraction", n_v, 64'h0000_0000_0DCB_A988);
    nv = 1; nv2 = 1;
    @(negedge clk); valid = 1; wr = 0; lvl = 2'd1; #5;
    chk(b_st == 3 && !b_mv, "R10 level1 undefined", {62'd0, b_st}, 3);
    @(posedge clk); #1; valid = 0; nv = 0; nv2 = 0;
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direct();
    t_override();
    t_el0_el1();
    t_encoding();
    t_nohyp_narrow();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule